// File: doc/BRIEF.md
# Two-Bank Graphics RAM Command Sequencer

This block sits on the controller side of a two-bank synchronous graphics RAM. It takes one request at a time (read or write, bank, row, start column, beat count) and turns it into a closed-page command sequence on the memory pins: open the row, issue the column command, stream the burst, then close the bank. Chip select, row strobe, column strobe and write enable are driven as one 4-bit command code. The block also drives the row/column address, the bank-select bit, the per-byte mask lines and the write-data drivers. Read beats are captured from the data bus a fixed CAS latency after the read command and handed to the requester.

Each bank has its own timers for activate-to-column, activate-to-close and close-to-reopen. A command waits in its state until its bank's timer reaches zero. Because the timers are per bank, a request to the bank that was not just closed can open at once. A request to the same bank waits out the close-to-reopen window.

A request may ask for fewer beats than the programmed burst length. A short read ends when the bank is closed right after the last wanted beat, with in-flight beats still arriving. A short write masks every byte from the cycle after its last written beat up to and including the close command, and the close comes no sooner than the write-recovery window after that last beat.

The sequencer states are:
- IDLE: waits for a request.
- ACTIVATE: opens the row once the close-to-reopen window has passed.
- COLCMD: issues read or write once the activate-to-column window has passed.
- RDBURST: streams the remaining read beats.
- WRBURST: streams the remaining write beats.
- RDLWAIT: holds the write-recovery gap with all bytes masked.
- PRECHARGE: closes the bank once the activate-to-close window has passed.

The transitions are:
- IDLE to ACTIVATE on an accepted request.
- ACTIVATE to COLCMD when the activate fires.
- COLCMD to RDBURST or WRBURST when more beats remain.
- COLCMD to PRECHARGE for a single read beat, or for a single write beat when the recovery window is one cycle.
- COLCMD to RDLWAIT for a single write beat otherwise.
- RDBURST to PRECHARGE on the last beat.
- WRBURST to RDLWAIT, or to PRECHARGE when the recovery window is one cycle, on the last beat.
- RDLWAIT to PRECHARGE when the recovery count expires.
- PRECHARGE to IDLE when the close fires.

Top module: `sgr_cmd_seq`

## Requirements
- R1: After reset the command is NOP, req_ready is 1, rd_valid is 0, mem_dq_oe is 0 and mem_dqm is all zeros. The command code {cs_n,ras_n,cas_n,we_n} has these values: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010.
- R2: On ACTIVATE, mem_addr carries the request row. On READ and WRITE it carries the zero-extended start column. On PRECHARGE it is all zeros. mem_ba carries the request bank for every command.
- R3: ACTIVATE is issued in the cycle after the request is accepted, or T_RP cycles after that bank's last PRECHARGE, whichever is later. A PRECHARGE of the other bank does not delay it.
- R4: READ or WRITE is issued exactly T_RCD cycles after the ACTIVATE of the same request.
- R5: In the WRITE cycle and in each following write beat cycle, mem_dq_out carries wr_data, mem_dq_oe and wr_take are 1, and mem_dqm bit k equals the inverse of wr_be bit k. Bit k covers data bits 8k+7:8k.
- R6: A read word present on mem_dq_in exactly CAS_LAT cycles after a read beat is presented on rd_data with rd_valid high one cycle later. The beats arrive in consecutive cycles in burst order.
- R7: A read delivers exactly the requested number of beats. Its PRECHARGE is issued at the later of (ACTIVATE + T_RAS) and (READ + length).
- R8: After the last write beat, mem_dqm is all ones up to and including the PRECHARGE. That PRECHARGE is issued at the later of (ACTIVATE + T_RAS) and (last beat + T_RDL).
- R9: PRECHARGE is never issued before T_RAS cycles have passed since that bank's ACTIVATE.
- R10: A req_len of 0, or one greater than BURST_LEN, is treated as a full burst of BURST_LEN beats.
- R11: req_ready is 1 only in IDLE. While it is 1, the command is NOP and mem_dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Beats wanted (0 or above BURST_LEN means full burst) |
| wr_data | input | DATA_W | Current write beat |
| wr_be | input | DATA_W/8 | Byte enables of the current write beat |
| wr_take | output | 1 | Current write beat is consumed this cycle |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | rd_data holds a new read word |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ROW_W | Row or column address |
| mem_ba | output | 1 | Bank select |
| mem_dqm | output | DATA_W/8 | Byte mask lines |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data returned from the memory |

## Verification
The hardest situation to reach is a short write whose close command lands inside the burst window while tRAS, and not write recovery, sets the close time. A second hard case is a reopen right after a close, where the two banks must see different wait times. The bench reaches both by sending requests back to back with no idle gap between them. One case is a two-beat write with mixed byte enables. Another is a one-beat read that tRAS holds open. A third is a bank swap straight after a close, followed by a return to that same bank. A memory model on the pins checks every timing window. It applies the byte masks and cuts bursts at the close, and full-burst read-backs then show that masked bytes and masked beats kept their old contents.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

    // Command code packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_ACT  = 4'b0011,
        CMD_RD   = 4'b0101,
        CMD_WR   = 4'b0100,
        CMD_PRE  = 4'b0010
    } sgr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVATE,
        ST_COLCMD,
        ST_RDBURST,
        ST_WRBURST,
        ST_RDLWAIT,
        ST_PRECHARGE
    } sgr_state_e;

    // Larger of two integers, used for counter sizing
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sgr_bank_timer.sv
module sgr_bank_timer #(
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic pre,
    output logic rcd_ok,
    output logic ras_ok,
    output logic rp_ok
);
    localparam int TMAX = sgr_pkg::imax(sgr_pkg::imax(T_RCD, T_RAS), T_RP);
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RAS_LD = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);

    logic [CW-1:0] rcd_cnt, ras_cnt, rp_cnt;

    // Each counter is loaded at the command edge and counts down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            ras_cnt <= '0;
            rp_cnt  <= '0;
        end else begin
            if (act) begin
                rcd_cnt <= RCD_LD;
                ras_cnt <= RAS_LD;
            end else begin
                if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
                if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
            end
            if (pre)
                rp_cnt <= RP_LD;
            else if (rp_cnt != '0)
                rp_cnt <= rp_cnt - 1'b1;
        end
    end

    assign rcd_ok = (rcd_cnt == '0);
    assign ras_ok = (ras_cnt == '0);
    assign rp_ok  = (rp_cnt == '0);

endmodule

// File: rtl/sgr_beat_ctr.sv
module sgr_beat_ctr #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] rem;

    // rem holds the beats still to come after the current one
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_len - 1'b1;
        else if (step && rem != '0)
            rem <= rem - 1'b1;
    end

    assign last = (rem == LEN_W'(1));

endmodule

// File: rtl/sgr_rd_capture.sv
module sgr_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] pipe;

    // pipe[k] is high CAS_LAT-relative: k+1 cycles after a wanted beat
    generate
        if (CAS_LAT == 1) begin : g_pipe1
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= beat_in;
            end
        end else begin : g_pipen
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[CAS_LAT-2:0], beat_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1]) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sgr_cmd_seq.sv
module sgr_cmd_seq
    import sgr_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int T_RDL     = 2,
    parameter int LEN_W     = $clog2(BURST_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W/8-1:0]  wr_be,
    output logic                 wr_take,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 mem_cs_n,
    output logic                 mem_ras_n,
    output logic                 mem_cas_n,
    output logic                 mem_we_n,
    output logic [ROW_W-1:0]     mem_addr,
    output logic                 mem_ba,
    output logic [DATA_W/8-1:0]  mem_dqm,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in
);
    localparam int NBANK    = 2;
    localparam int BYTES    = DATA_W / 8;
    localparam int RDL_W    = (T_RDL > 2) ? $clog2(T_RDL) : 1;
    localparam logic [RDL_W-1:0] RDL_LD = RDL_W'((T_RDL >= 2) ? T_RDL - 2 : 0);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BURST_LEN);

    sgr_state_e state, state_nx;

    logic                lat_write;
    logic                lat_bank;
    logic [ROW_W-1:0]    lat_row;
    logic [COL_W-1:0]    lat_col;
    logic [LEN_W-1:0]    lat_len;
    logic [RDL_W-1:0]    rdl_cnt;

    logic [NBANK-1:0]    rcd_ok, ras_ok, rp_ok;
    logic                act_fire, col_fire, pre_fire;
    logic                beat_last;
    logic                burst_step;
    logic                rd_beat;
    sgr_cmd_e            cmd;
    logic [LEN_W-1:0]    len_eff;

    // Out-of-range lengths select a full burst
    assign len_eff = (req_len == '0 || req_len > FULL_LEN) ? FULL_LEN : req_len;

    // ---------------- per-bank timing windows ----------------
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            sgr_bank_timer #(
                .T_RCD (T_RCD),
                .T_RAS (T_RAS),
                .T_RP  (T_RP)
            ) u_timer (
                .clk    (clk),
                .rst_n  (rst_n),
                .act    (act_fire && (lat_bank == 1'(b))),
                .pre    (pre_fire && (lat_bank == 1'(b))),
                .rcd_ok (rcd_ok[b]),
                .ras_ok (ras_ok[b]),
                .rp_ok  (rp_ok[b])
            );
        end
    endgenerate

    assign act_fire = (state == ST_ACTIVATE)  && rp_ok[lat_bank];
    assign col_fire = (state == ST_COLCMD)    && rcd_ok[lat_bank];
    assign pre_fire = (state == ST_PRECHARGE) && ras_ok[lat_bank];

    assign burst_step = (state == ST_RDBURST) || (state == ST_WRBURST);

    sgr_beat_ctr #(
        .LEN_W (LEN_W)
    ) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (col_fire),
        .load_len (lat_len),
        .step     (burst_step),
        .last     (beat_last)
    );

    sgr_rd_capture #(
        .CAS_LAT (CAS_LAT),
        .DATA_W  (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_in  (rd_beat),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // ---------------- request latch and recovery count ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_bank  <= 1'b0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_len   <= FULL_LEN;
            rdl_cnt   <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                lat_write <= req_write;
                lat_bank  <= req_bank;
                lat_row   <= req_row;
                lat_col   <= req_col;
                lat_len   <= len_eff;
            end
            if (state_nx == ST_RDLWAIT && state != ST_RDLWAIT)
                rdl_cnt <= RDL_LD;
            else if (state == ST_RDLWAIT && rdl_cnt != '0)
                rdl_cnt <= rdl_cnt - 1'b1;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (req_valid) state_nx = ST_ACTIVATE;
            ST_ACTIVATE:
                if (act_fire) state_nx = ST_COLCMD;
            ST_COLCMD:
                if (col_fire) begin
                    if (lat_len == LEN_W'(1)) begin
                        if (lat_write && T_RDL > 1) state_nx = ST_RDLWAIT;
                        else                        state_nx = ST_PRECHARGE;
                    end else begin
                        state_nx = lat_write ? ST_WRBURST : ST_RDBURST;
                    end
                end
            ST_RDBURST:
                if (beat_last) state_nx = ST_PRECHARGE;
            ST_WRBURST:
                if (beat_last) state_nx = (T_RDL > 1) ? ST_RDLWAIT : ST_PRECHARGE;
            ST_RDLWAIT:
                if (rdl_cnt == '0) state_nx = ST_PRECHARGE;
            ST_PRECHARGE:
                if (pre_fire) state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd        = CMD_NOP;
        mem_addr   = '0;
        mem_dqm    = '0;
        mem_dq_out = '0;
        mem_dq_oe  = 1'b0;
        wr_take    = 1'b0;
        rd_beat    = 1'b0;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_ACTIVATE:
                if (act_fire) begin
                    cmd      = CMD_ACT;
                    mem_addr = lat_row;
                end
            ST_COLCMD:
                if (col_fire) begin
                    mem_addr = ROW_W'(lat_col);
                    if (lat_write) begin
                        cmd        = CMD_WR;
                        wr_take    = 1'b1;
                        mem_dq_oe  = 1'b1;
                        mem_dq_out = wr_data;
                        mem_dqm    = ~wr_be;
                    end else begin
                        cmd     = CMD_RD;
                        rd_beat = 1'b1;
                    end
                end
            ST_RDBURST: rd_beat = 1'b1;
            ST_WRBURST: begin
                wr_take    = 1'b1;
                mem_dq_oe  = 1'b1;
                mem_dq_out = wr_data;
                mem_dqm    = ~wr_be;
            end
            ST_RDLWAIT: mem_dqm = {BYTES{1'b1}};
            ST_PRECHARGE: begin
                if (lat_write) mem_dqm = {BYTES{1'b1}};
                if (pre_fire)  cmd     = CMD_PRE;
            end
            default: ;
        endcase
    end

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
    assign mem_ba = lat_bank;

endmodule

// File: rtl/sgr_cmd_seq_chk.sv
module sgr_cmd_seq_chk #(
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3
) (
    input logic clk,
    input logic rst_n,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic mem_ba,
    input logic mem_dq_oe,
    input logic wr_take,
    input logic rd_valid,
    input logic req_ready
);
    localparam logic [7:0] RCD8 = 8'(T_RCD);
    localparam logic [7:0] RAS8 = 8'(T_RAS);
    localparam logic [7:0] RP8  = 8'(T_RP);
    localparam logic [7:0] VLO8 = 8'(CAS_LAT + 1);
    localparam logic [7:0] VHI8 = 8'(CAS_LAT + BURST_LEN);

    logic [3:0] cmd_now;
    logic [7:0] since_act [2];
    logic [7:0] since_pre [2];
    logic [7:0] since_rd;

    assign cmd_now = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    // Saturating cycle counters since the last command of each kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                since_act[b] <= 8'd0;
                since_pre[b] <= 8'hFF;
            end
            since_rd <= 8'hFF;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (cmd_now == 4'b0011 && mem_ba == 1'(b)) since_act[b] <= 8'd1;
                else if (since_act[b] != 8'hFF)           since_act[b] <= since_act[b] + 8'd1;
                if (cmd_now == 4'b0010 && mem_ba == 1'(b)) since_pre[b] <= 8'd1;
                else if (since_pre[b] != 8'hFF)           since_pre[b] <= since_pre[b] + 8'd1;
            end
            if (cmd_now == 4'b0101)      since_rd <= 8'd1;
            else if (since_rd != 8'hFF)  since_rd <= since_rd + 8'd1;
        end
    end

    p_reopen_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == 4'b0011) |-> (since_pre[mem_ba] >= RP8));

    p_col_after_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == 4'b0101 || cmd_now == 4'b0100) |-> (since_act[mem_ba] >= RCD8));

    p_close_after_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == 4'b0010) |-> (since_act[mem_ba] >= RAS8));

    p_write_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == 4'b0100) |-> (mem_dq_oe && wr_take));

    p_oe_only_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> wr_take);

    p_read_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd >= VLO8 && since_rd <= VHI8));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_now == 4'b0111 && !mem_dq_oe));

endmodule

bind sgr_cmd_seq sgr_cmd_seq_chk #(
    .BURST_LEN (BURST_LEN),
    .CAS_LAT   (CAS_LAT),
    .T_RCD     (T_RCD),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_dq_oe (mem_dq_oe),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .req_ready (req_ready)
);

// File: tb/sgr_cmd_seq_test.sv
`timescale 1ns/1ps
module sgr_cmd_seq_test;
    localparam int ROW_W = 11, COL_W = 8, DATA_W = 32, BL = 4, CL = 2;
    localparam int T_RCD = 2, T_RAS = 5, T_RP = 3, T_RDL = 2;
    localparam int LEN_W = $clog2(BL + 1);
    localparam int BYTES = DATA_W / 8;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_bank = 0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [DATA_W-1:0] wr_data;
    logic [BYTES-1:0] wr_be;
    logic req_ready, wr_take, rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_dq_oe;
    logic [ROW_W-1:0] mem_addr;
    logic [BYTES-1:0] mem_dqm;
    logic [DATA_W-1:0] mem_dq_out;
    logic [DATA_W-1:0] mem_dq_in = '0;

    sgr_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST_LEN(BL),
                  .CAS_LAT(CL), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
                  .T_RDL(T_RDL)) uut (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mkey(int b, int r, int c);
        return (b << 20) | (r << 8) | c;
    endfunction
    function automatic logic [31:0] initval(int k);
        return 32'h5A00_0000 ^ k;
    endfunction
    function automatic int wcol(int c, int i);
        return (c & ~(BL - 1)) | ((c + i) & (BL - 1));
    endfunction

    // ---------------- memory model on the pins ----------------
    logic [31:0] mdl_mem [int];
    int act_cyc [2] = '{-1000, -1000};
    int pre_cyc [2] = '{-1000, -1000};
    int last_act, last_col, last_pre, pre_count = 0, rd_cmd_cyc = -1000;
    logic [BYTES-1:0] dqm_at_pre;
    logic [ROW_W-1:0] open_row [2];
    int rd_t = -1000, rd_b, rd_c, rd_stop;
    int wr_t = -1000, wr_b, wr_c, wr_stop, last_wbeat = -1000;
    logic [ROW_W-1:0] rd_r, wr_r;

    function automatic logic [31:0] mdl_get(int k);
        return mdl_mem.exists(k) ? mdl_mem[k] : initval(k);
    endfunction

    always @(negedge clk) begin
        logic [3:0] c;
        c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
        case (c)
            4'b0011: begin
                chk(cyc - pre_cyc[mem_ba] >= T_RP, "R3 reopen gap", cyc - pre_cyc[mem_ba], T_RP);
                open_row[mem_ba] = mem_addr; act_cyc[mem_ba] = cyc; last_act = cyc;
            end
            4'b0101, 4'b0100: begin
                chk(cyc - act_cyc[mem_ba] >= T_RCD, "R4 column gap", cyc - act_cyc[mem_ba], T_RCD);
                last_col = cyc;
                if (c == 4'b0101) begin
                    rd_t = cyc; rd_b = mem_ba; rd_r = open_row[mem_ba];
                    rd_c = int'(mem_addr); rd_stop = cyc + BL; rd_cmd_cyc = cyc;
                end else begin
                    wr_t = cyc; wr_b = mem_ba; wr_r = open_row[mem_ba];
                    wr_c = int'(mem_addr); wr_stop = cyc + BL;
                end
            end
            4'b0010: begin
                chk(cyc - act_cyc[mem_ba] >= T_RAS, "R9 close gap", cyc - act_cyc[mem_ba], T_RAS);
                if (wr_b == int'(mem_ba) && cyc < wr_stop) begin
                    wr_stop = cyc;
                    chk(cyc - last_wbeat >= T_RDL, "R8 recovery gap", cyc - last_wbeat, T_RDL);
                end
                if (rd_b == int'(mem_ba) && cyc < rd_stop) rd_stop = cyc;
                chk(mem_addr == '0, "R2 close address", mem_addr, 0);
                pre_cyc[mem_ba] = cyc; last_pre = cyc; dqm_at_pre = mem_dqm;
                pre_count++;
            end
            default: ;
        endcase
        if (cyc - wr_t >= 0 && cyc - wr_t < BL && cyc < wr_stop) begin
            int k;
            k = mkey(wr_b, int'(wr_r), wcol(wr_c, cyc - wr_t));
            if (mem_dqm != '1) begin
                logic [31:0] w;
                chk(mem_dq_oe, "R5 driver on during beat", mem_dq_oe, 1);
                w = mdl_get(k);
                for (int j = 0; j < BYTES; j++)
                    if (!mem_dqm[j]) w[8*j +: 8] = mem_dq_out[8*j +: 8];
                mdl_mem[k] = w;
                last_wbeat = cyc;
            end
        end
        if (cyc - CL - rd_t >= 0 && cyc - CL - rd_t < BL && rd_t + (cyc - CL - rd_t) < rd_stop)
            mem_dq_in = mdl_get(mkey(rd_b, int'(rd_r), wcol(rd_c, cyc - CL - rd_t)));
        else
            mem_dq_in = 32'hBAD0_0000 ^ cyc;
    end

    // ---------------- write beat source ----------------
    logic [31:0] wbeat_d [8];
    logic [BYTES-1:0] wbeat_be [8];
    int wcount = 0, wbase = 0;
    always @(posedge clk) if (wr_take) wcount <= wcount + 1;
    assign wr_data = wbeat_d[(wcount - wbase) & 7];
    assign wr_be   = wbeat_be[(wcount - wbase) & 7];

    // ---------------- scoreboard ----------------
    typedef struct { logic [31:0] d; bit first; } exp_t;
    exp_t exp_q [$];
    logic [31:0] ref_mem [int];
    function automatic logic [31:0] ref_get(int k);
        return ref_mem.exists(k) ? ref_mem[k] : initval(k);
    endfunction

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R7 extra read beat", rd_data, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rd_data == e.d, "R6 read data", rd_data, e.d);
                if (e.first) chk(cyc == rd_cmd_cyc + CL + 1, "R6 first beat timing", cyc, rd_cmd_cyc + CL + 1);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_req(input bit wr, input int b, input int r, input int c, input int len,
                           input logic [31:0] seed, input logic [BYTES-1:0] be0);
        int n, acc, n0, exp_act, exp_pre, prev_pre;
        n = (len == 0 || len > BL) ? BL : len;
        prev_pre = pre_cyc[b];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            wbeat_d[i]  = seed + 32'h0101_0101 * i;
            wbeat_be[i] = (i == 0) ? be0 : '1;
        end
        wbase = wcount;
        req_write = wr; req_bank = b[0]; req_row = ROW_W'(r); req_col = COL_W'(c);
        req_len = LEN_W'(len); req_valid = 1;
        acc = cyc; n0 = pre_count;
        if (wr) begin
            for (int i = 0; i < n; i++) begin
                int k;
                logic [31:0] w;
                k = mkey(b, r, wcol(c, i));
                w = ref_get(k);
                for (int j = 0; j < BYTES; j++)
                    if (wbeat_be[i][j]) w[8*j +: 8] = wbeat_d[i][8*j +: 8];
                ref_mem[k] = w;
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.d = ref_get(mkey(b, r, wcol(c, i))); e.first = (i == 0);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        req_valid = 0;
        while (pre_count == n0) @(posedge clk);
        exp_act = (acc + 1 > prev_pre + T_RP) ? acc + 1 : prev_pre + T_RP;
        chk(last_act == exp_act, "R3 activate cycle", last_act, exp_act);
        chk(last_col == last_act + T_RCD, "R4 column cycle", last_col, last_act + T_RCD);
        exp_pre = wr ? last_col + n - 1 + T_RDL : last_col + n;
        if (last_act + T_RAS > exp_pre) exp_pre = last_act + T_RAS;
        chk(last_pre == exp_pre, wr ? "R8 close cycle" : "R7 close cycle", last_pre, exp_pre);
        if (wr) chk(dqm_at_pre == '1, "R8 mask at close", dqm_at_pre, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R1 reset command",
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
        chk(req_ready == 1, "R1 reset ready", req_ready, 1);
        chk(rd_valid == 0 && mem_dq_oe == 0, "R1 reset idle outputs", {rd_valid, mem_dq_oe}, 0);
        chk(mem_dqm == '0, "R1 reset mask", mem_dqm, 0);
        chk(req_ready && {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R11 idle quiet", req_ready, 1);
        run_req(1, 0, 5, 0, 4, 32'h1111_0000, 4'hF);   // full write
        run_req(0, 0, 5, 0, 4, 0, 4'hF);               // full read-back
        run_req(1, 1, 7, 2, 4, 32'h2222_0000, 4'hF);   // other bank, wrapped start
        run_req(0, 1, 7, 0, 0, 0, 4'hF);               // R10: length 0 gives full burst
        run_req(1, 0, 5, 1, 2, 32'h3333_0000, 4'b0101);// R8: short masked write
        run_req(0, 0, 5, 0, 4, 0, 4'hF);               // confirm masked bytes/beats kept
        run_req(0, 1, 7, 3, 1, 0, 4'hF);               // R7: tRAS-limited single read
        run_req(0, 1, 7, 1, 3, 0, 4'hF);               // R3: same bank, reopen waits T_RP
        run_req(1, 1, 9, 4, 7, 32'h4444_0000, 4'hE);   // R10: oversize length
        run_req(0, 0, 5, 2, 2, 0, 4'hF);               // R3: bank swap, no wait
        run_req(0, 1, 9, 4, 4, 0, 4'hF);
        run_req(1, 0, 3, 3, 1, 32'h5555_0000, 4'h3);   // single-beat write
        run_req(0, 0, 3, 0, 4, 0, 4'hF);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all beats delivered", exp_q.size(), 0);
        chk(rd_valid == 0 && req_ready == 1, "R11 back to idle", {rd_valid, req_ready}, 2'b01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule